// File: doc/BRIEF.md
# Receive Frame Byte Tracker (MAC side)

This block sits on the MAC side of a byte-wide, clock-synchronous receive path from a radio PHY. Each received octet arrives on `data` and is valid on the same clock edge at which `data_en` is high. The MAC's own receive enable `rx_en` is also an input. The block decodes the data rate and the 12-bit frame length from the leading physical-layer header. It then marks the eleven MAC-header octets and the length-counted payload/FCS octets with strobes, repeating each octet on `byte_out`.

Nothing on the interface marks the three trailing status octets (signal strength, link quality, error code). The block finds them by counting octets against the decoded length, so gaps in `data_en` never disturb it. Pad octets that the PHY sends after a payload error are counted like any other body octet. A zero-length frame goes straight from the MAC header to the status octets.

When the MAC rejects a frame by dropping `rx_en`, counting stops. The block waits a fixed number of cycles (`ABORT_WAIT`) and then reports the last three octets that were delivered as the status octets. Each frame ends in exactly one `status_valid` pulse.

Top module: `rx_frame_tracker`

## Requirements
- R1: While reset is asserted, and until the first octet is accepted after it, every output is zero.
- R2: A frame starts when `data_en` and `rx_en` are both high while the block is idle. That octet is octet 0, and `rate` takes its bits [7:4]. Octet 1 holds the length bits [7:0] and octet 2 holds the length bits [11:8] in bits [3:0]. One cycle after octet 2 is sampled, `frame_len` holds the length and `len_valid` pulses for one cycle.
- R3: Octets are counted only on edges where `data_en` is high. Idle cycles inside a frame advance nothing and raise no strobe.
- R4: Octets 5 to 15 each raise `mac_hdr_stb` for one cycle, one cycle after they are sampled, with the octet on `byte_out`.
- R5: Octets 16 to 15+LEN each raise `body_stb` in the same way. The two strobes are never high together.
- R6: Octets 16+LEN, 17+LEN and 18+LEN are the status octets. One cycle after the last of them is sampled, `rssi` and `lqi` hold the first two and `rx_err` holds bits [4:0] of the third. In that same cycle `status_valid` pulses high for exactly one cycle, once per frame.
- R7: With LEN = 0, the status octets immediately follow octet 15 and `body_stb` never rises.
- R8: Status octets are still located correctly when they arrive after pad octets and after long pauses in `data_en`.
- R9: If `rx_en` is sampled low during a frame, no further strobe rises. `ABORT_WAIT` edges after that edge, `status_valid` pulses. The last three octets delivered in the frame, oldest first, appear on `rssi`, `lqi` and `rx_err` (bits [4:0]). If fewer than three octets were delivered, the missing older ones read as zero.
- R10: While idle with `rx_en` low, octets on `data` are ignored: no frame starts, and no strobe, `len_valid` or `status_valid` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | MAC receive enable; a low level during a frame rejects the frame |
| data_en | input | 1 | Qualifies `data` on this edge |
| data | input | 8 | Received octet from the PHY |
| rate | output | RATE_W | Data-rate field of octet 0 |
| frame_len | output | LEN_W | Decoded frame length |
| len_valid | output | 1 | One-cycle pulse when `frame_len` is updated |
| mac_hdr_stb | output | 1 | MAC-header octet on `byte_out` |
| body_stb | output | 1 | Payload/FCS/pad octet on `byte_out` |
| byte_out | output | 8 | Last accepted octet |
| rssi | output | 8 | First status octet |
| lqi | output | 8 | Second status octet |
| rx_err | output | 5 | Error code from the third status octet |
| status_valid | output | 1 | One-cycle pulse per frame when the status fields are updated |

## Verification
Every result is registered once. The strobes, `byte_out`, `rate`, `len_valid`/`frame_len` and `status_valid` are all due in the cycle after the edge that sampled the octet which causes them. A rejected frame's status is due exactly `ABORT_WAIT` edges after the edge that first sees `rx_en` low. The bench drives one input set at each falling edge and checks the outputs at the next falling edge, so every check lands one rising edge after its stimulus. In the abort case it counts edges from the `rx_en` drop and expects `status_valid` low on every earlier edge and high on that one. Expected strobes and status values are derived from the octet index and the length, across a sweep of lengths, rates and gap patterns.

// File: rtl/rxft_pkg.sv
package rxft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_ABORT = 2'd2
  } rxft_state_e;
endpackage

// File: rtl/rxft_plcp_decode.sv
// Captures rate and length from the leading header octets.
module rxft_plcp_decode #(
  parameter int LEN_W  = 12,
  parameter int RATE_W = 4,
  parameter int IDX_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              take,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        data,
  output logic [RATE_W-1:0] rate,
  output logic [LEN_W-1:0]  frame_len,
  output logic              len_valid
);
  localparam int HI_W = LEN_W - 8;

  logic [7:0] len_lo_q;
  logic       lo_en, hi_en;

  assign lo_en = take && (idx == IDX_W'(1));
  assign hi_en = take && (idx == IDX_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate      <= '0;
      len_lo_q  <= '0;
      frame_len <= '0;
      len_valid <= 1'b0;
    end else begin
      if (start) rate <= data[7 -: RATE_W];
      if (lo_en) len_lo_q <= data;
      if (hi_en) frame_len <= {data[HI_W-1:0], len_lo_q};
      len_valid <= hi_en;
    end
  end
endmodule

// File: rtl/rxft_abort_timer.sv
// Counts the wait after a MAC reject before status is taken.
module rxft_abort_timer #(
  parameter int ABORT_WAIT = 66
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(ABORT_WAIT + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = run && (cnt_q == TW'(ABORT_WAIT - 1));
  assign cnt_en = arm || (run && !expire);

  always_comb begin
    cnt_d = cnt_q + TW'(1);
    if (arm) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rxft_status_capture.sv
// Three-octet history; on fire the newest three become the status fields.
module rxft_status_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       shift,
  input  logic       fire,
  input  logic [7:0] data,
  output logic [7:0] rssi,
  output logic [7:0] lqi,
  output logic [4:0] rx_err,
  output logic       status_valid
);
  logic [7:0] h0_q, h1_q, h2_q;
  logic [7:0] n0, n1, n2;
  logic       hist_en;

  assign hist_en = clear || shift;

  always_comb begin
    n0 = h0_q;
    n1 = h1_q;
    n2 = h2_q;
    if (clear) begin
      n0 = data;
      n1 = '0;
      n2 = '0;
    end else if (shift) begin
      n0 = data;
      n1 = h0_q;
      n2 = h1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0_q <= '0;
      h1_q <= '0;
      h2_q <= '0;
    end else if (hist_en) begin
      h0_q <= n0;
      h1_q <= n1;
      h2_q <= n2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rssi         <= '0;
      lqi          <= '0;
      rx_err       <= '0;
      status_valid <= 1'b0;
    end else begin
      if (fire) begin
        rssi   <= n2;
        lqi    <= n1;
        rx_err <= n0[4:0];
      end
      status_valid <= fire;
    end
  end
endmodule

// File: rtl/rx_frame_tracker.sv
module rx_frame_tracker #(
  parameter int LEN_W         = 12,
  parameter int RATE_W        = 4,
  parameter int PLCP_BYTES    = 5,
  parameter int MAC_HDR_BYTES = 11,
  parameter int ABORT_WAIT    = 66
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              data_en,
  input  logic [7:0]        data,
  output logic [RATE_W-1:0] rate,
  output logic [LEN_W-1:0]  frame_len,
  output logic              len_valid,
  output logic              mac_hdr_stb,
  output logic              body_stb,
  output logic [7:0]        byte_out,
  output logic [7:0]        rssi,
  output logic [7:0]        lqi,
  output logic [4:0]        rx_err,
  output logic              status_valid
);
  import rxft_pkg::*;

  // One spare bit over the length covers the header and status octets.
  localparam int IDX_W      = LEN_W + 1;
  localparam int BODY_START = PLCP_BYTES + MAC_HDR_BYTES;
  localparam logic [IDX_W-1:0] HDR_LO  = IDX_W'(PLCP_BYTES);
  localparam logic [IDX_W-1:0] BODY_LO = IDX_W'(BODY_START);

  rxft_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             start, in_frame, in_abort, abort_now, take;
  logic             last_byte, expire, fire, shift;
  logic [IDX_W-1:0] body_end, stat_end;
  logic             hdr_hit, body_hit;

  assign in_frame  = (state_q == ST_FRAME);
  assign in_abort  = (state_q == ST_ABORT);
  assign start     = (state_q == ST_IDLE) && rx_en && data_en;
  assign abort_now = in_frame && !rx_en;
  assign take      = in_frame && rx_en && data_en;
  assign body_end  = BODY_LO + IDX_W'(frame_len);
  assign stat_end  = body_end + IDX_W'(2);
  assign last_byte = take && (idx_q == stat_end);
  assign fire      = last_byte || expire;
  assign shift     = (in_frame || in_abort) && data_en;
  assign hdr_hit   = take && (idx_q >= HDR_LO) && (idx_q < BODY_LO);
  assign body_hit  = take && (idx_q >= BODY_LO) && (idx_q < body_end);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_FRAME;
      ST_FRAME: begin
        if (abort_now)      state_d = ST_ABORT;
        else if (last_byte) state_d = ST_IDLE;
      end
      ST_ABORT: if (expire) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign idx_en = start || take;
  always_comb begin
    idx_d = idx_q + IDX_W'(1);
    if (start) idx_d = IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_hdr_stb <= 1'b0;
      body_stb    <= 1'b0;
      byte_out    <= '0;
    end else begin
      mac_hdr_stb <= hdr_hit;
      body_stb    <= body_hit;
      if (idx_en) byte_out <= data;
    end
  end

  rxft_plcp_decode #(.LEN_W(LEN_W), .RATE_W(RATE_W), .IDX_W(IDX_W)) u_plcp (
    .clk(clk), .rst_n(rst_n), .start(start), .take(take), .idx(idx_q),
    .data(data), .rate(rate), .frame_len(frame_len), .len_valid(len_valid)
  );

  rxft_abort_timer #(.ABORT_WAIT(ABORT_WAIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(abort_now), .run(in_abort), .expire(expire)
  );

  rxft_status_capture u_status (
    .clk(clk), .rst_n(rst_n), .clear(start), .shift(shift), .fire(fire),
    .data(data), .rssi(rssi), .lqi(lqi), .rx_err(rx_err),
    .status_valid(status_valid)
  );
endmodule

// File: rtl/rxft_checker.sv
module rxft_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic data_en,
  input logic len_valid,
  input logic mac_hdr_stb,
  input logic body_stb,
  input logic status_valid
);
  // R6: status pulse lasts one cycle
  p_status_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |=> !status_valid);

  // R5: strobes exclusive
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mac_hdr_stb && body_stb));

  // R3/R4: header strobe follows an accepted octet
  p_hdr_needs_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mac_hdr_stb |-> $past(data_en && rx_en));

  // R3/R5: body strobe follows an accepted octet
  p_body_needs_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    body_stb |-> $past(data_en && rx_en));

  // R2: length update follows a qualified octet
  p_len_needs_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    len_valid |-> $past(data_en));

  // R9: no strobe alongside the status pulse
  p_no_stb_at_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> (!mac_hdr_stb && !body_stb));
endmodule

bind rx_frame_tracker rxft_checker u_rxft_checker (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .data_en(data_en),
  .len_valid(len_valid), .mac_hdr_stb(mac_hdr_stb), .body_stb(body_stb),
  .status_valid(status_valid)
);

// File: tb/tb_rx_frame_tracker.sv
`timescale 1ns/1ps
module tb_rx_frame_tracker;
  localparam int W = 66;

  logic       clk, rst_n, rx_en, data_en;
  logic [7:0] data;
  logic [3:0] rate;
  logic [11:0] frame_len;
  logic       len_valid, mac_hdr_stb, body_stb, status_valid;
  logic [7:0] byte_out, rssi, lqi;
  logic [4:0] rx_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rx_frame_tracker #(.ABORT_WAIT(W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .data_en(data_en), .data(data),
    .rate(rate), .frame_len(frame_len), .len_valid(len_valid),
    .mac_hdr_stb(mac_hdr_stb), .body_stb(body_stb), .byte_out(byte_out),
    .rssi(rssi), .lqi(lqi), .rx_err(rx_err), .status_valid(status_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic en_r, input logic de, input logic [7:0] d);
    rx_en = en_r; data_en = de; data = d;
    @(negedge clk);
  endtask

  function automatic logic [7:0] octet(input int k, input int rt, input int len, input int seed);
    int total = 19 + len;
    if (k == 0)         return {rt[3:0], 4'h5};
    if (k == 1)         return len[7:0];
    if (k == 2)         return {4'h9, len[11:8]};
    if (k == total - 3) return 8'(seed ^ 8'h3C);
    if (k == total - 2) return 8'(seed + 1);
    if (k == total - 1) return {3'b111, seed[4:0]};
    return 8'(k * 7 + seed);
  endfunction

  // checks for octet k just sampled
  task automatic check_octet(input int k, input int rt, input int len, input logic [7:0] b,
                             input bit last, input string st_tag);
    bit eh = (k >= 5 && k <= 15);
    bit eb = (k >= 16 && k < 16 + len);
    bit ok = (mac_hdr_stb == eh) && (body_stb == eb) && (!(eh || eb) || byte_out == b);
    chk(ok, (k < 16) ? "R4" : "R5", {mac_hdr_stb, body_stb, byte_out}, {eh, eb, b});
    if (k == 0) chk(rate == rt[3:0], "R2 rate", rate, rt[3:0]);
    if (k == 2) chk(len_valid && frame_len == len[11:0], "R2 len", {len_valid, frame_len}, {1'b1, len[11:0]});
    if (k == 3) chk(!len_valid, "R2 pulse", len_valid, 0);
    chk(status_valid == last, st_tag, status_valid, last);
  endtask

  task automatic gap_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 8'hEE);
      chk(!mac_hdr_stb && !body_stb && !status_valid, "R3 gap",
          {mac_hdr_stb, body_stb, status_valid}, 0);
    end
  endtask

  task automatic send_frame(input int rt, input int len, input int gap, input int seed);
    int total = 19 + len;
    string st_tag = (len == 0) ? "R7 status" : ((gap > 0) ? "R8 status" : "R6 status");
    for (int k = 0; k < total; k++) begin
      logic [7:0] b = octet(k, rt, len, seed);
      if (gap > 0 && k > 0 && (k % 3 == 1 || k >= total - 3)) gap_cycles(gap);
      step(1'b1, 1'b1, b);
      check_octet(k, rt, len, b, k == total - 1, st_tag);
    end
    chk(rssi == octet(total - 3, rt, len, seed), st_tag, rssi, octet(total - 3, rt, len, seed));
    chk(lqi == octet(total - 2, rt, len, seed), st_tag, lqi, octet(total - 2, rt, len, seed));
    chk(rx_err == seed[4:0], st_tag, rx_err, seed[4:0]);
  endtask

  task automatic abort_frame(input int nb, input int ma, input int seed);
    logic [7:0] h0 = 0, h1 = 0, h2 = 0;
    for (int k = 0; k < nb; k++) begin
      logic [7:0] b = octet(k, 3, 40, seed);
      step(1'b1, 1'b1, b);
      h2 = h1; h1 = h0; h0 = b;
      check_octet(k, 3, 40, b, 1'b0, "R9 early");
    end
    for (int c = 0; c <= W; c++) begin
      logic de = (c < ma);
      logic [7:0] d = 8'(8'h80 + c + seed);
      step(1'b0, de, d);
      if (de) begin h2 = h1; h1 = h0; h0 = d; end
      chk(!mac_hdr_stb && !body_stb, "R9 strobe", {mac_hdr_stb, body_stb}, 0);
      chk(status_valid == (c == W), "R9 timing", status_valid, c == W);
    end
    chk(rssi == h2 && lqi == h1 && rx_err == h0[4:0], "R9 fields",
        {rssi, lqi, rx_err}, {h2, h1, h0[4:0]});
    step(1'b1, 1'b0, 8'h00);
    chk(!status_valid, "R9 once", status_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; data_en = 1'b0; data = '0;
    repeat (3) @(negedge clk);
    step(1'b1, 1'b1, 8'hA5);
    chk({rate, frame_len, len_valid, mac_hdr_stb, body_stb, byte_out, rssi, lqi, rx_err, status_valid} == '0,
        "R1 in reset", int'(byte_out), 0);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 8'h00);
    chk({rate, frame_len, len_valid, mac_hdr_stb, body_stb, byte_out, rssi, lqi, rx_err, status_valid} == '0,
        "R1 after reset", int'(byte_out), 0);

    // R10: stray octets while idle and rx_en low
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b1, 8'(8'h40 + i));
      chk(!mac_hdr_stb && !body_stb && !len_valid && !status_valid && byte_out == 8'h00,
          "R10 ignored", {mac_hdr_stb, body_stb, len_valid, status_valid, byte_out}, 0);
    end

    for (int len = 0; len <= 6; len++)
      for (int gap = 0; gap <= 2; gap++)
        send_frame((len * 3 + gap) % 16, len, gap, len * 16 + gap + 5);
    send_frame(15, 300, 4, 8'h61);
    send_frame(9, 4095, 0, 8'h2B);

    abort_frame(20, 5, 8'h11);   // inside the body
    abort_frame(7, 0, 8'h22);    // inside the MAC header
    abort_frame(2, 0, 8'h33);    // only two octets delivered
    send_frame(6, 3, 1, 8'h4D);  // normal frame after aborts

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule